// File: doc/BRIEF.md
# Multi-Mode Timer Channel with Pulse Measurement

This block is one 16-bit timer channel that can be run in three ways, picked by a 2-bit mode field. As a periodic divider it counts down from a software-loaded value on an internal count source and emits a one-clock pulse each time it passes zero. As an event counter it uses the same down-count and reload path, but it counts edges on an external pin or one-cycle events from a neighbouring channel. As a measurement unit it counts up on the internal source between selected edges of the external pin and latches the result for software to read.

The internal count source is selected from four options: the system clock, the clock divided by 8, a prescaled clock set by a 4-bit code n (no division for n=0, division by 2n for n=1 to 15), and a slow source. In this implementation the slow source is the clock divided by 32. The external pin passes through a two-flop synchronizer before any edge is detected. The counter advances only while the start bit is high.

Top module: `multi_timer`

## Requirements
- R1: While reset is held and after it is released, `tickOut` and `ovfFlag` are low until the counter produces an event.
- R2: `clkSel` selects the internal count source. 00 ticks every clock, 01 ticks every 8 clocks and 11 ticks every 32 clocks. With 10, `preCode`=0 ticks every clock and `preCode`=n (1 to 15) ticks every 2n clocks.
- R3: In mode 00, a reload value n produces a one-clock `tickOut` pulse every n+1 source ticks, for any n from 0 to 0xFFFF.
- R4: In modes 00 and 01, a write stores `wrData` as the reload value. If `startEn` is low, the write also loads the counter, which is then visible on `rdData`. A rising `startEn` loads the counter from the reload value.
- R5: In modes 00 and 01, `rdData` shows the counter, which steps down by one per count event. While `startEn` is low, the counter holds and ignores count events.
- R6: In mode 01 with `chainSel`=0, the counter counts edges of the synchronized `pinIn`: rising edges when `risePol`=1 and falling edges when `risePol`=0. Edges of the other polarity have no effect.
- R7: In mode 01 with `chainSel`=1, each clock with `chainEvt` high counts one event, and `pinIn` has no effect.
- R8: In mode 10 with `widthMeas`=0, `rdData` shows the number of source ticks between the two most recent edges of the polarity chosen by `risePol`. This count includes the tick that coincides with the closing edge.
- R9: In mode 10 with `widthMeas`=1, every edge of `pinIn` closes a measurement. After a falling edge, `rdData` shows the high time in source ticks. After a rising edge, it shows the low time.
- R10: In mode 10, writes do not change `rdData`.
- R11: In mode 10, when the counter passes 0xFFFF without a measured edge, it wraps to 0, `ovfFlag` is set and `tickOut` pulses for one clock. A rising `startEn` clears `ovfFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startEn | input | 1 | Counter runs while high |
| modeSel | input | 2 | 00 timer, 01 event counter, 10 measurement, 11 halted |
| widthMeas | input | 1 | In measurement mode: 1 width, 0 period |
| clkSel | input | 2 | Internal count source select |
| preCode | input | 4 | Prescaler code n for source 10 |
| chainSel | input | 1 | In event mode: 1 counts `chainEvt`, 0 counts pin edges |
| risePol | input | 1 | Active edge: 1 rising, 0 falling |
| wrEn | input | 1 | Word write strobe |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Counter (modes 00/01) or captured measurement (mode 10) |
| pinIn | input | 1 | Asynchronous external input |
| chainEvt | input | 1 | Event pulse from a neighbouring channel |
| tickOut | output | 1 | One-clock underflow/overflow pulse |
| ovfFlag | output | 1 | Measurement overflow flag |

## Verification
If the prescaler state is wrong, the spacing of `tickOut` shows it within one reload period, because a zero reload makes every source tick visible. If the synchronizer or edge detection is wrong, the counter read back a few clocks after a pin pulse is off by one or more, or a measured width is off by the length of the sync delay. If the counter never wraps or the flag logic is broken, the error appears only after 65536 undisturbed ticks, so that window is driven in full and checked both before and after the wrap.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_MEAS  = 2'b10,
    MODE_HALT  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SRC_F1   = 2'b00,
    SRC_F8   = 2'b01,
    SRC_F2N  = 2'b10,
    SRC_SLOW = 2'b11
  } src_e;

  // strobes from control to datapath, one clock each
  typedef struct packed {
    logic tick;        // count one step this cycle
    logic isMeas;      // measurement mode selected
    logic edgeHit;     // measured edge seen this cycle
    logic wrReload;    // store wrData into reload register
    logic loadWr;      // load counter from wrData
    logic loadReload;  // load counter from reload register
    logic measStart;   // clear counter and flag for a new measurement run
  } strobe_t;
endpackage

// File: rtl/mtmr_presc.sv
module mtmr_presc #(
  parameter int PRE_W    = 4,
  parameter int F8_LOG2  = 3,
  parameter int SLOW_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       clkSel,
  input  logic [PRE_W-1:0] preCode,
  output logic             srcTick
);
  import mtmr_pkg::*;

  localparam int DIV_W  = PRE_W + 1;
  localparam int FREE_W = (SLOW_LOG2 > F8_LOG2) ? SLOW_LOG2 : F8_LOG2;

  logic [FREE_W-1:0] freeCnt;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  divLimit;
  logic              f8Tick, slowTick, f2nTick, divWrap;

  assign divLimit = {preCode, 1'b0} - DIV_W'(1);
  assign divWrap  = (divCnt >= divLimit);
  assign f2nTick  = (preCode == '0) ? 1'b1 : divWrap;
  assign f8Tick   = &freeCnt[F8_LOG2-1:0];
  assign slowTick = &freeCnt[SLOW_LOG2-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeCnt <= '0;
      divCnt  <= '0;
    end else begin
      freeCnt <= freeCnt + FREE_W'(1);
      if (preCode == '0 || divWrap) divCnt <= '0;
      else                          divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_comb begin
    unique case (src_e'(clkSel))
      SRC_F1:   srcTick = 1'b1;
      SRC_F8:   srcTick = f8Tick;
      SRC_F2N:  srcTick = f2nTick;
      SRC_SLOW: srcTick = slowTick;
      default:  srcTick = 1'b0;
    endcase
  end

  // R2
  f8_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcTick && clkSel == 2'b01) |=> (clkSel != 2'b01 || !srcTick));

  // R2
  f1_always_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 2'b00) |-> srcTick);
endmodule

// File: rtl/mtmr_ctrl.sv
module mtmr_ctrl #(
  parameter int PRE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startEn,
  input  logic [1:0]         modeSel,
  input  logic               widthMeas,
  input  logic [1:0]         clkSel,
  input  logic [PRE_W-1:0]   preCode,
  input  logic               chainSel,
  input  logic               risePol,
  input  logic               wrEn,
  input  logic               pinIn,
  input  logic               chainEvt,
  output mtmr_pkg::strobe_t  str
);
  import mtmr_pkg::*;

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] syncQ;
  logic              prevQ, startQ;
  logic              pinSync, pinRise, pinFall, startRise;
  logic              srcTick, evtTick, activeEdge, measEdge;
  logic              isTimer, isEvent, isMeas, usesReload;

  mtmr_presc #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .preCode(preCode), .srcTick(srcTick)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= '0;
      prevQ  <= 1'b0;
      startQ <= 1'b0;
    end else begin
      syncQ  <= {syncQ[SYNC_N-2:0], pinIn};
      prevQ  <= syncQ[SYNC_N-1];
      startQ <= startEn;
    end
  end

  assign pinSync    = syncQ[SYNC_N-1];
  assign pinRise    = pinSync & ~prevQ;
  assign pinFall    = ~pinSync & prevQ;
  assign startRise  = startEn & ~startQ;
  assign isTimer    = (mode_e'(modeSel) == MODE_TIMER);
  assign isEvent    = (mode_e'(modeSel) == MODE_EVENT);
  assign isMeas     = (mode_e'(modeSel) == MODE_MEAS);
  assign usesReload = isTimer | isEvent;
  assign activeEdge = risePol ? pinRise : pinFall;
  assign evtTick    = chainSel ? chainEvt : activeEdge;
  assign measEdge   = widthMeas ? (pinRise | pinFall) : activeEdge;

  always_comb begin
    str            = '0;
    str.isMeas     = isMeas;
    str.tick       = startEn & ((isTimer & srcTick) | (isEvent & evtTick) | (isMeas & srcTick));
    str.edgeHit    = startEn & isMeas & ~startRise & measEdge;
    str.wrReload   = wrEn & usesReload;
    str.loadWr     = wrEn & usesReload & ~startEn;
    str.loadReload = startRise & usesReload;
    str.measStart  = startRise & isMeas;
  end

  // R8
  edge_meas_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.edgeHit |-> (modeSel == 2'b10 && startEn));

  // R3
  timer_f1_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startEn && modeSel == 2'b00 && clkSel == 2'b00) |-> str.tick);

  // R5
  stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !startEn |-> !str.tick);
endmodule

// File: rtl/mtmr_dp.sv
module mtmr_dp #(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mtmr_pkg::strobe_t str,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              tickOut,
  output logic              ovfFlag
);
  import mtmr_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count, reloadQ, capQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      reloadQ <= '0;
      capQ    <= '0;
      tickOut <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      tickOut <= 1'b0;
      if (str.wrReload) reloadQ <= wrData;
      if (str.loadWr) begin
        count <= wrData;
      end else if (str.loadReload) begin
        count <= reloadQ;
      end else if (str.measStart) begin
        count   <= '0;
        ovfFlag <= 1'b0;
      end else if (str.isMeas) begin
        if (str.tick && count == CNT_MAX) begin
          ovfFlag <= 1'b1;
          tickOut <= 1'b1;
        end
        if (str.edgeHit) begin
          capQ  <= count + CNT_W'(str.tick);
          count <= '0;
        end else if (str.tick) begin
          count <= count + CNT_W'(1);
        end
      end else if (str.tick) begin
        if (count == '0) begin
          count   <= reloadQ;
          tickOut <= 1'b1;
        end else begin
          count <= count - CNT_W'(1);
        end
      end
    end
  end

  assign rdData = str.isMeas ? capQ : count;

  // R3
  underflow_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickOut && !$past(str.isMeas)) |-> ($past(count) == '0));

  // R11
  ovf_meas_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> ($past(str.isMeas) && tickOut));

  // R11
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickOut && $past(str.isMeas) && !$past(str.loadWr) && !$past(str.loadReload)) |-> (count == '0));

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(str.tick) && !$past(str.edgeHit) && !$past(str.loadWr) &&
     !$past(str.loadReload) && !$past(str.measStart)) |-> $stable(count));
endmodule

// File: rtl/multi_timer.sv
module multi_timer #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startEn,
  input  logic [1:0]       modeSel,
  input  logic             widthMeas,
  input  logic [1:0]       clkSel,
  input  logic [PRE_W-1:0] preCode,
  input  logic             chainSel,
  input  logic             risePol,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  input  logic             pinIn,
  input  logic             chainEvt,
  output logic             tickOut,
  output logic             ovfFlag
);
  import mtmr_pkg::*;

  strobe_t str;

  mtmr_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startEn(startEn), .modeSel(modeSel),
    .widthMeas(widthMeas), .clkSel(clkSel), .preCode(preCode),
    .chainSel(chainSel), .risePol(risePol), .wrEn(wrEn),
    .pinIn(pinIn), .chainEvt(chainEvt), .str(str)
  );

  mtmr_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .wrData(wrData),
    .rdData(rdData), .tickOut(tickOut), .ovfFlag(ovfFlag)
  );
endmodule

// File: tb/test_multi_timer.sv
`timescale 1ns/1ps
module test_multi_timer;
  logic        clk = 1'b0;
  logic        rstN, startEn, widthMeas, chainSel, risePol, wrEn, pinIn, chainEvt;
  logic [1:0]  modeSel, clkSel;
  logic [3:0]  preCode;
  logic [15:0] wrData, rdData;
  logic        tickOut, ovfFlag;

  multi_timer i_multi_timer (
    .clk(clk), .rstN(rstN), .startEn(startEn), .modeSel(modeSel),
    .widthMeas(widthMeas), .clkSel(clkSel), .preCode(preCode),
    .chainSel(chainSel), .risePol(risePol), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .chainEvt(chainEvt),
    .tickOut(tickOut), .ovfFlag(ovfFlag)
  );

  always #4 clk = ~clk;  // 125 MHz

  typedef struct { string tag; int sel; int exp; } item_t;
  item_t expQ[$];
  int applied = 0, miscomp = 0;
  int cyc = 0, lastTickCyc = 0, lastInt = 0, tickCnt = 0;
  bit seenTick = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: track tick spacing, then compare queued expectations
  always @(negedge clk) begin
    if (rstN && tickOut) begin
      if (seenTick) lastInt = cyc - lastTickCyc;
      lastTickCyc = cyc;
      seenTick = 1;
      tickCnt++;
    end
    while (expQ.size() > 0) begin
      item_t it;
      int act;
      it = expQ.pop_front();
      case (it.sel)
        0: act = int'(rdData);
        1: act = int'(ovfFlag);
        2: act = lastInt;
        3: act = tickCnt;
        default: act = int'(tickOut);
      endcase
      applied++;
      if (act != it.exp) begin
        miscomp++;
        $display("FAIL %s: actual %0d expected %0d", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input string tag, input int sel, input int exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    expQ.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wrWord(input logic [15:0] v);
    wrEn = 1'b1; wrData = v; step(1); wrEn = 1'b0;
  endtask

  task automatic pinPulse(input int hi, input int lo);
    pinIn = 1'b1; step(hi); pinIn = 1'b0; step(lo);
  endtask

  task automatic finishRun();
    step(2);
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      miscomp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
      $finish;
    end
  end

  initial begin
    int base;
    rstN = 0; startEn = 0; modeSel = 2'b00; widthMeas = 0; clkSel = 2'b00;
    preCode = 4'd0; chainSel = 0; risePol = 1; wrEn = 0; wrData = '0;
    pinIn = 0; chainEvt = 0;
    step(5);
    push("R1 tickOut in reset", 4, 0);
    push("R1 ovfFlag in reset", 1, 0);
    step(1);
    rstN = 1; step(3);
    push("R1 tickOut after reset", 4, 0);
    push("R1 ovfFlag after reset", 1, 0);

    // timer mode, reload 0: every source tick shows on tickOut
    wrWord(16'd0); startEn = 1; step(50);
    push("R2 f1 spacing", 2, 1);
    clkSel = 2'b01; step(100); push("R2 f8 spacing", 2, 8);
    clkSel = 2'b11; step(200); push("R2 slow /32 spacing", 2, 32);
    clkSel = 2'b10; preCode = 4'd3; step(100); push("R2 prescaler n=3", 2, 6);
    preCode = 4'd15; step(200); push("R2 prescaler n=15", 2, 30);
    preCode = 4'd0; step(50); push("R2 prescaler n=0", 2, 1);
    clkSel = 2'b00; wrWord(16'd4); step(60);
    push("R3 reload 4 divides by 5", 2, 5);
    wrWord(16'd11); step(80);
    push("R3 reload 11 divides by 12", 2, 12);

    // event mode, pin rising edges
    startEn = 0; step(2); modeSel = 2'b01; wrWord(16'd5); step(3);
    push("R4 write while stopped loads counter", 0, 5);
    startEn = 1; step(2);
    pinPulse(4, 4); pinPulse(4, 4); step(6);
    push("R5 counts down on rising edges", 0, 3);
    startEn = 0; step(1);
    pinPulse(4, 4); pinPulse(4, 4); step(6);
    push("R5 holds while stopped", 0, 3);
    wrWord(16'd2); startEn = 1; step(2);
    base = tickCnt;
    repeat (9) pinPulse(4, 4);
    step(6);
    push("R6 rising edges reload 2", 3, base + 3);

    // falling polarity
    startEn = 0; step(1); risePol = 0; wrWord(16'd2); startEn = 1; step(2);
    base = tickCnt;
    repeat (6) pinPulse(4, 4);
    step(6);
    push("R6 falling edges only", 3, base + 2);

    // chained events, pin ignored
    startEn = 0; step(1); chainSel = 1; risePol = 1; wrWord(16'd1);
    startEn = 1; step(2);
    base = tickCnt;
    repeat (4) pinPulse(4, 4);
    step(6);
    push("R7 pin ignored in chain mode", 3, base);
    repeat (6) begin chainEvt = 1; step(1); chainEvt = 0; step(2); end
    step(3);
    push("R7 chain events reload 1", 3, base + 3);

    // period measurement
    startEn = 0; step(1); chainSel = 0; modeSel = 2'b10; widthMeas = 0;
    clkSel = 2'b00; startEn = 1; step(2);
    repeat (3) pinPulse(10, 27);
    push("R8 period 37 at f1", 0, 37);
    clkSel = 2'b01;
    repeat (3) pinPulse(40, 40);
    push("R8 period 80 at f8", 0, 10);
    wrWord(16'h1234); step(3);
    push("R10 write ignored in measurement", 0, 10);

    // width measurement
    clkSel = 2'b00; widthMeas = 1;
    pinIn = 1; step(12); pinIn = 0; step(6);
    push("R9 high time", 0, 12);
    step(14); pinIn = 1; step(6);
    push("R9 low time", 0, 20);
    pinIn = 0; step(10);

    // overflow
    widthMeas = 0; startEn = 0; step(2); startEn = 1; step(1);
    base = tickCnt;
    push("R11 flag clear at start", 1, 0);
    step(65000);
    push("R11 no flag before wrap", 1, 0);
    step(600);
    push("R11 flag after wrap", 1, 1);
    push("R11 single pulse on wrap", 3, base + 1);
    startEn = 0; step(1); startEn = 1; step(2);
    push("R11 start clears flag", 1, 0);

    done = 1;
    finishRun();
  end
endmodule